// File: doc/BRIEF.md
# Serial ADC Output Emulator

This block stands in for the digital side of a 12-bit successive-approximation converter with a three-wire serial read port, so that serial reader logic can be exercised against a known target. It runs on a fast system clock and watches an active-low chip select and a serial clock. Both inputs are taken to be synchronous to that system clock, and their edges are found by comparing each one against its value in the previous cycle.

A falling chip select does three things. It freezes the parallel sample input, drops the track indicator (hold), and enables the data driver with the first leading zero. Each serial clock falling edge then advances the frame by one bit: four zeros first, then the sample from its top bit down. After the thirteenth falling edge, the track indicator returns on the next serial clock rising edge. The driver turns off on the sixteenth falling edge. Raising chip select early aborts the frame and turns the driver off at once.

A power-down request is taken only when a frame completes. A frame started from power-down wakes the part, carries all-zero data and is flagged invalid. The frame after it carries a real sample. The three-state data line is modelled as a value plus an output enable.

Top module: `ser_adc_emu`

## Requirements
- R1: One system clock after a chip select falling edge (cs_ni 1 to 0), sdo_oe_o goes high and track_o goes low. The driver is enabled at no other time.
- R2: While the driver is enabled, sdo_o carries frame bit k after k serial clock falling edges (sclk_i 1 to 0). Bits 0 to 3 are zero and bits 4 to 15 are sample bits 11 down to 0, so bit 0 appears with the chip select fall.
- R3: The data shifted out is the sample_i value present at the chip select falling edge. Later changes of sample_i do not alter the frame.
- R4: track_o goes high again one system clock after the first serial clock rising edge that follows the 13th falling edge of the frame.
- R5: On the 16th serial clock falling edge, sdo_oe_o goes low and frame_done_o pulses high for one system clock.
- R6: If chip select rises before the 16th falling edge, then one system clock later sdo_oe_o is low, track_o is high and abort_o pulses high for one cycle.
- R7: After a frame completes, further serial clock edges while chip select stays low leave sdo_oe_o low. A new frame needs a new chip select falling edge.
- R8: pd_req_i is sampled only on the 16th falling edge. If it is high there, pd_o goes high with frame_done_o. At any other time, and on an abort, pd_req_i has no effect.
- R9: A frame started while pd_o is high clears pd_o, shifts out 16 zeros and keeps data_valid_o low. The next frame is valid again, with data_valid_o equal to sdo_oe_o.
- R10: A chip select rise in the same cycle as a serial clock fall is treated as an abort (R6), not as a shift.
- R11: After reset, sdo_oe_o, pd_o, frame_done_o and abort_o are low and track_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock, idle high |
| pd_req_i | input | 1 | Power-down request, sampled at frame end |
| sample_i | input | DATA_W | Parallel sample to be converted |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Serial data output enable |
| data_valid_o | output | 1 | Driven frame carries a real sample |
| track_o | output | 1 | High while the sampler tracks the input |
| pd_o | output | 1 | Part is powered down |
| frame_done_o | output | 1 | One-cycle pulse on a completed frame |
| abort_o | output | 1 | One-cycle pulse on an aborted frame |

## Verification
Every output is registered behind one combinational edge compare, so each response is due exactly one system clock after the input change that causes it. The driver task changes the inputs on the falling clock edge. It then queues the full output state expected after the next rising edge. The monitor pops that entry one nanosecond after the rising edge and compares it, so every entry is checked in the one cycle its stimulus makes due. Pulses are checked both in their due cycle and for being low in every other cycle.

// File: rtl/ser_adc_emu_pkg.sv
package ser_adc_emu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_PDOWN  = 2'd2
  } emu_state_e;
endpackage

// File: rtl/ser_adc_edge.sv
module ser_adc_edge #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[i] <= RST_VAL[i];
      else         prev_q[i] <= sig_i[i];
    end
    assign rise_o[i] = sig_i[i] & ~prev_q[i];
    assign fall_o[i] = ~sig_i[i] & prev_q[i];
  end
endmodule

// File: rtl/ser_adc_shift.sv
module ser_adc_shift #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned LEAD_W = 4,
  localparam int unsigned FW = LEAD_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              blank_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              sdo_o
);
  logic [FW-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sreg_q <= '0;
    else if (load_i)  sreg_q <= blank_i ? '0 : {{LEAD_W{1'b0}}, data_i};
    else if (shift_i) sreg_q <= {sreg_q[FW-2:0], 1'b0};
  end

  assign sdo_o = sreg_q[FW-1];

  // leading zero present right after a load
  a_r2_lead_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_i) |-> !sdo_o);
endmodule

// File: rtl/ser_adc_ctrl.sv
module ser_adc_ctrl
  import ser_adc_emu_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned HOLD_EDGES = 13,
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_fall_i,
  input  logic cs_rise_i,
  input  logic sck_fall_i,
  input  logic sck_rise_i,
  input  logic pd_req_i,
  output logic load_o,
  output logic blank_o,
  output logic shift_o,
  output logic oe_o,
  output logic valid_o,
  output logic track_o,
  output logic pd_o,
  output logic done_o,
  output logic abort_o
);
  localparam logic [CNT_W-1:0] HOLD_C = CNT_W'(HOLD_EDGES);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(FRAME_BITS);

  emu_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             rel_q;
  logic             inv_q;
  logic             active;

  assign active  = (state_q == ST_ACTIVE);
  assign cnt_nxt = cnt_q + 1'b1;
  assign load_o  = !active && cs_fall_i;
  assign blank_o = (state_q == ST_PDOWN);
  assign shift_o = active && !cs_rise_i && sck_fall_i;
  assign pd_o    = (state_q == ST_PDOWN);
  assign valid_o = oe_o && !inv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rel_q   <= 1'b0;
      inv_q   <= 1'b0;
      oe_o    <= 1'b0;
      track_o <= 1'b1;
      done_o  <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      abort_o <= 1'b0;
      if (active) begin
        if (cs_rise_i) begin          // abort wins over a coincident shift
          state_q <= ST_IDLE;
          oe_o    <= 1'b0;
          track_o <= 1'b1;
          inv_q   <= 1'b0;
          abort_o <= 1'b1;
        end else if (sck_fall_i) begin
          cnt_q <= cnt_nxt;
          if (cnt_nxt == HOLD_C) rel_q <= 1'b1;
          if (cnt_nxt == LAST_C) begin
            state_q <= pd_req_i ? ST_PDOWN : ST_IDLE;
            oe_o    <= 1'b0;
            inv_q   <= 1'b0;
            done_o  <= 1'b1;
          end
        end else if (sck_rise_i && rel_q) begin
          track_o <= 1'b1;
        end
      end else if (cs_fall_i) begin
        state_q <= ST_ACTIVE;
        cnt_q   <= '0;
        rel_q   <= 1'b0;
        oe_o    <= 1'b1;
        track_o <= 1'b0;
        inv_q   <= (state_q == ST_PDOWN);
      end
    end
  end

  a_r1_oe_from_cs_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> $past(cs_fall_i));
  a_r4_track_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(track_o) |-> $past(sck_rise_i || cs_rise_i));
  a_r5_done_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(sck_fall_i) && !$past(cs_rise_i) && !oe_o));
  a_r6_abort_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> ($past(cs_rise_i) && !oe_o && track_o));
  a_r8_pd_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_o) |-> done_o);
  a_r11_pulses_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, abort_o}));
endmodule

// File: rtl/ser_adc_emu.sv
module ser_adc_emu #(
  parameter int unsigned DATA_W     = 12,
  parameter int unsigned LEAD_W     = 4,
  parameter int unsigned HOLD_EDGES = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              pd_req_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              data_valid_o,
  output logic              track_o,
  output logic              pd_o,
  output logic              frame_done_o,
  output logic              abort_o
);
  localparam int unsigned FRAME_BITS = LEAD_W + DATA_W;

  logic [1:0] rise, fall;
  logic       load, blank, shift;

  ser_adc_edge #(.W(2), .RST_VAL(2'b11)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({cs_ni, sclk_i}),
    .rise_o (rise),
    .fall_o (fall)
  );

  ser_adc_ctrl #(.FRAME_BITS(FRAME_BITS), .HOLD_EDGES(HOLD_EDGES)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_fall_i  (fall[1]),
    .cs_rise_i  (rise[1]),
    .sck_fall_i (fall[0]),
    .sck_rise_i (rise[0]),
    .pd_req_i   (pd_req_i),
    .load_o     (load),
    .blank_o    (blank),
    .shift_o    (shift),
    .oe_o       (sdo_oe_o),
    .valid_o    (data_valid_o),
    .track_o    (track_o),
    .pd_o       (pd_o),
    .done_o     (frame_done_o),
    .abort_o    (abort_o)
  );

  ser_adc_shift #(.DATA_W(DATA_W), .LEAD_W(LEAD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .blank_i (blank),
    .shift_i (shift),
    .data_i  (sample_i),
    .sdo_o   (sdo_o)
  );
endmodule

// File: tb/ser_adc_emu_bench.sv
module ser_adc_emu_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b1, pd_req = 1'b0;
  logic [11:0] sample = '0;
  logic sdo, oe, valid, track, pd, done, abort;

  always #2 clk = ~clk;

  ser_adc_emu u_ser_adc_emu (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .pd_req_i(pd_req),
    .sample_i(sample), .sdo_o(sdo), .sdo_oe_o(oe), .data_valid_o(valid),
    .track_o(track), .pd_o(pd), .frame_done_o(done), .abort_o(abort)
  );

  typedef struct {
    logic oe, sdo, valid, track, pd, done, abort;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;

  // reference model state
  logic m_pcs = 1'b1, m_psck = 1'b1;
  logic m_act = 0, m_rel = 0, m_inv = 0, m_oe = 0, m_trk = 1, m_pd = 0;
  int   m_cnt = 0;
  logic [15:0] m_sh = '0;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic cs, input logic sck, input logic pdr,
                      input logic [11:0] smp, input string tag);
    exp_t e;
    logic csf, csr, sf, sr;
    @(negedge clk);
    cs_n = cs; sclk = sck; pd_req = pdr; sample = smp;
    csf = m_pcs & ~cs; csr = ~m_pcs & cs; sf = m_psck & ~sck; sr = ~m_psck & sck;
    m_pcs = cs; m_psck = sck;
    e.done = 0; e.abort = 0;
    if (m_act) begin
      if (csr) begin
        m_act = 0; m_oe = 0; m_trk = 1; m_inv = 0; e.abort = 1;
      end else if (sf) begin
        m_cnt++; m_sh = m_sh << 1;
        if (m_cnt == 13) m_rel = 1;
        if (m_cnt == 16) begin
          m_act = 0; m_oe = 0; m_inv = 0; e.done = 1; m_pd = pdr;
        end
      end else if (sr && m_rel) m_trk = 1;
    end else if (csf) begin
      m_act = 1; m_oe = 1; m_cnt = 0; m_rel = 0; m_trk = 0;
      m_inv = m_pd; m_sh = m_pd ? 16'h0 : {4'h0, smp}; m_pd = 0;
    end
    e.oe = m_oe; e.sdo = m_sh[15]; e.valid = m_oe & ~m_inv; e.track = m_trk;
    e.pd = m_pd; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "sdo_oe_o", oe, e.oe);
      if (e.oe) chk(e.tag, "sdo_o", sdo, e.sdo);
      chk(e.tag, "data_valid_o", valid, e.valid);
      chk(e.tag, "track_o", track, e.track);
      chk(e.tag, "pd_o", pd, e.pd);
      chk(e.tag, "frame_done_o", done, e.done);
      chk(e.tag, "abort_o", abort, e.abort);
    end
  end

  // cs fall, n serial clock cycles (fall then rise), cs rise
  task automatic frame(input logic [11:0] smp, input int n, input logic pd_mid,
                       input logic pd_end, input string tag);
    step(1'b0, 1'b1, pd_mid, smp, tag);
    step(1'b0, 1'b1, pd_mid, ~smp, "R3");
    for (int i = 1; i <= n; i++) begin
      logic p;
      p = (i == 16) ? pd_end : pd_mid;
      step(1'b0, 1'b0, p, smp ^ 12'h5A5, tag);
      step(1'b0, 1'b0, pd_mid, ~smp, tag);
      step(1'b0, 1'b1, pd_mid, smp, (i == 13) ? "R4" : tag);
      step(1'b0, 1'b1, pd_mid, smp, tag);
    end
    step(1'b1, 1'b1, pd_mid, smp, (n < 16) ? "R6" : "R5");
    step(1'b1, 1'b1, 1'b0, smp, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "sdo_oe_o", oe, 1'b0);
    chk("R11", "track_o", track, 1'b1);
    chk("R11", "pd_o", pd, 1'b0);
    chk("R11", "frame_done_o", done, 1'b0);
    chk("R11", "abort_o", abort, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    step(1'b1, 1'b1, 1'b0, '0, "R11");
    frame(12'hA5C, 16, 1'b0, 1'b0, "R2");
    frame(12'hFFF, 16, 1'b1, 1'b0, "R8");
    frame(12'h3C1, 7, 1'b1, 1'b1, "R6");
    frame(12'h801, 18, 1'b0, 1'b0, "R7");
    frame(12'h123, 16, 1'b0, 1'b1, "R8");
    step(1'b1, 1'b0, 1'b0, 12'h777, "R8");
    step(1'b1, 1'b1, 1'b0, 12'h777, "R8");
    frame(12'hFFF, 16, 1'b0, 1'b0, "R9");
    frame(12'h9B6, 16, 1'b0, 1'b0, "R9");
    // abort coincident with a serial clock fall
    step(1'b0, 1'b1, 1'b0, 12'h0F0, "R1");
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 1'b0, 1'b0, 12'h0F0, "R2");
      step(1'b0, 1'b1, 1'b0, 12'h0F0, "R2");
    end
    step(1'b1, 1'b0, 1'b0, 12'h0F0, "R10");
    step(1'b1, 1'b1, 1'b0, 12'h0F0, "R10");
    frame(12'h555, 16, 1'b0, 1'b0, "R1");
    repeat (4) step(1'b1, 1'b1, 1'b0, '0, "R5");
    repeat (3) @(posedge clk);
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule